// File: doc/BRIEF.md
# Dual General-Purpose I/O Port Controller

This block drives and samples two general-purpose pin groups behind a small byte-wide register bus: port A has eight pins and port B has six. Each pin has three pieces of state: an output latch, a direction bit and an active-low pull-control bit. From these the block produces the output value, output enable, pullup enable and pulldown enable for each pad. The incoming pad levels go through a two-stage synchronizer before software can see them.

A data-register read is resolved bit by bit. A pin set as an output returns its latch. A pin set as an input returns its synchronized level. A write to a data register always updates the latch, whatever the direction. A pin that is currently an input therefore keeps the written value and drives it once it is turned into an output. The pull-control registers are write-only.

Each pin's pull device is either a pullup or a pulldown, chosen at build time by a per-port mask parameter. A pulldown is switched off while its pin is an output. A pullup follows only its control bit.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: After reset, every direction bit and every pull-control bit is 0, and every output latch is 0. Every `*_oe` is therefore 0. `*_pu_en` equals the port's pullup mask, and `*_pd_en` equals the inverse of that mask.
- R2: A bus write to the direction address of a port (A at 0x04, B at 0x05) sets the port's direction bits, where 1 means output and 0 means input. In the next cycle `*_oe` equals the written bits. Reading the same address returns them.
- R3: A bus write to a port's data address (A at 0x00, B at 0x01) loads the port's output latch, and `*_out` shows the latch from the next cycle on.
- R4: A data-register read returns the latch value for every bit whose direction bit is 1.
- R5: A data-register read returns the synchronized pin level for every bit whose direction bit is 0. A pin change that is present before clock edge k can be read after edge k+1, and not earlier.
- R6: A data write to an input pin stores the value without enabling the pad. Once the pin is later made an output, it drives the stored value.
- R7: The pull-control registers (A at 0x10, B at 0x11) are write-only, and a read of either address returns 0x00.
- R8: Pull control is active-low: a pull device can be enabled only while its control bit is 0.
- R9: A pulldown is enabled only when its control bit is 0 and its pin is an input. A pullup is enabled whenever its control bit is 0, whatever the direction.
- R10: Port B has only bits 0 to 5. Bits 6 and 7 of its data and direction reads are 0, and written values of those bits have no effect.
- R11: `bus_rdata` is 0x00 when there is no read cycle (`bus_sel` low or `bus_wr` high) and when a read targets an address that is not listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus cycle valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational in the read cycle |
| pa_in | input | 8 | Port A pad input levels |
| pa_out | output | 8 | Port A output latch value |
| pa_oe | output | 8 | Port A output enables |
| pa_pu_en | output | 8 | Port A pullup enables |
| pa_pd_en | output | 8 | Port A pulldown enables |
| pb_in | input | 6 | Port B pad input levels |
| pb_out | output | 6 | Port B output latch value |
| pb_oe | output | 6 | Port B output enables |
| pb_pu_en | output | 6 | Port B pullup enables |
| pb_pd_en | output | 6 | Port B pulldown enables |

## Verification
The assertions check on every cycle that:
- direction and data writes appear on the pad controls one cycle later;
- a pulldown is never on for a driven pin;
- pull-control reads and idle cycles return zero;
- the unused upper bits of port B always read as zero;
- output bits read back their latch.

Only the bench scenarios can show:
- the two-edge delay of the pin synchronizer;
- a value written while a pin was an input being driven after the direction flip;
- the per-pin split between pullups and pulldowns.

The bench's cycle-by-cycle reference model compares all of these against long runs of mixed register traffic.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  localparam int unsigned BUS_W = 8;
  typedef logic [BUS_W-1:0] bus_t;

  localparam bus_t ADR_A_DATA = 8'h00;
  localparam bus_t ADR_B_DATA = 8'h01;
  localparam bus_t ADR_A_DIR  = 8'h04;
  localparam bus_t ADR_B_DIR  = 8'h05;
  localparam bus_t ADR_A_PULL = 8'h10;
  localparam bus_t ADR_B_PULL = 8'h11;

  typedef struct packed {
    logic data;
    logic dir;
    logic pull;
  } port_wr_t;

  function automatic port_wr_t decode_wr(input logic wr_cyc, input bus_t addr,
                                         input bus_t a_data, input bus_t a_dir,
                                         input bus_t a_pull);
    port_wr_t r;
    r.data = wr_cyc && (addr == a_data);
    r.dir  = wr_cyc && (addr == a_dir);
    r.pull = wr_cyc && (addr == a_pull);
    return r;
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_n_o = ff2_q;
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned   W       = 8,
  parameter logic [W-1:0]  PU_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic         wr_pull,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] rd_dir,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pu_en,
  output logic [W-1:0] pd_en
);
  logic [W-1:0] lat_q, lat_d;
  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] pull_q, pull_d;
  logic [W-1:0] pin_s;

  gpio_pin_sync #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (pin_s)
  );

  // next-state
  always_comb begin
    lat_d  = wr_data ? wdata : lat_q;
    dir_d  = wr_dir  ? wdata : dir_q;
    pull_d = wr_pull ? wdata : pull_q;
  end

  // registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      dir_q  <= '0;
      pull_q <= '0;
    end else begin
      if (wr_data) lat_q  <= lat_d;
      if (wr_dir)  dir_q  <= dir_d;
      if (wr_pull) pull_q <= pull_d;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (PU_MASK[i]) begin : g_up
      assign pu_en[i] = ~pull_q[i];
      assign pd_en[i] = 1'b0;
    end else begin : g_dn
      assign pu_en[i] = 1'b0;
      assign pd_en[i] = ~pull_q[i] & ~dir_q[i];
    end
    assign rd_data[i] = dir_q[i] ? lat_q[i] : pin_s[i];
  end

  assign rd_dir  = dir_q;
  assign pin_out = lat_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_pair_ctrl.sv
module gpio_pair_ctrl
  import gpio_pair_pkg::*;
#(
  parameter int unsigned     A_W       = 8,
  parameter int unsigned     B_W       = 6,
  parameter logic [A_W-1:0]  A_PU_MASK = 8'h0F,
  parameter logic [B_W-1:0]  B_PU_MASK = 6'b101010
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  input  logic [A_W-1:0] pa_in,
  output logic [A_W-1:0] pa_out,
  output logic [A_W-1:0] pa_oe,
  output logic [A_W-1:0] pa_pu_en,
  output logic [A_W-1:0] pa_pd_en,
  input  logic [B_W-1:0] pb_in,
  output logic [B_W-1:0] pb_out,
  output logic [B_W-1:0] pb_oe,
  output logic [B_W-1:0] pb_pu_en,
  output logic [B_W-1:0] pb_pd_en
);
  logic     rst_n_int;
  logic     wr_cyc, rd_cyc;
  port_wr_t a_wr, b_wr;
  logic [A_W-1:0] a_rd_data, a_rd_dir;
  logic [B_W-1:0] b_rd_data, b_rd_dir;

  gpio_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_n_int)
  );

  assign wr_cyc = bus_sel &  bus_wr;
  assign rd_cyc = bus_sel & ~bus_wr;
  assign a_wr   = decode_wr(wr_cyc, bus_addr, ADR_A_DATA, ADR_A_DIR, ADR_A_PULL);
  assign b_wr   = decode_wr(wr_cyc, bus_addr, ADR_B_DATA, ADR_B_DIR, ADR_B_PULL);

  gpio_port #(.W(A_W), .PU_MASK(A_PU_MASK)) u_port_a (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_data(a_wr.data),
    .wr_dir (a_wr.dir),
    .wr_pull(a_wr.pull),
    .wdata  (bus_wdata[A_W-1:0]),
    .pin_in (pa_in),
    .rd_data(a_rd_data),
    .rd_dir (a_rd_dir),
    .pin_out(pa_out),
    .pin_oe (pa_oe),
    .pu_en  (pa_pu_en),
    .pd_en  (pa_pd_en)
  );

  gpio_port #(.W(B_W), .PU_MASK(B_PU_MASK)) u_port_b (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_data(b_wr.data),
    .wr_dir (b_wr.dir),
    .wr_pull(b_wr.pull),
    .wdata  (bus_wdata[B_W-1:0]),
    .pin_in (pb_in),
    .rd_data(b_rd_data),
    .rd_dir (b_rd_dir),
    .pin_out(pb_out),
    .pin_oe (pb_oe),
    .pu_en  (pb_pu_en),
    .pd_en  (pb_pd_en)
  );

  // read mux; pull registers and unmapped addresses fall to zero
  always_comb begin
    bus_rdata = '0;
    if (rd_cyc) begin
      case (bus_addr)
        ADR_A_DATA: bus_rdata = bus_t'(a_rd_data);
        ADR_B_DATA: bus_rdata = bus_t'(b_rd_data);
        ADR_A_DIR:  bus_rdata = bus_t'(a_rd_dir);
        ADR_B_DIR:  bus_rdata = bus_t'(b_rd_dir);
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pair_ctrl_chk.sv
module gpio_pair_ctrl_chk
  import gpio_pair_pkg::*;
#(
  parameter int unsigned A_W = 8,
  parameter int unsigned B_W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic [7:0]     bus_addr,
  input logic [7:0]     bus_wdata,
  input logic [7:0]     bus_rdata,
  input logic [A_W-1:0] pa_out,
  input logic [A_W-1:0] pa_oe,
  input logic [A_W-1:0] pa_pd_en,
  input logic [B_W-1:0] pb_out,
  input logic [B_W-1:0] pb_oe,
  input logic [B_W-1:0] pb_pd_en
);
  AST_DIR_A_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADR_A_DIR) |=> (pa_oe == $past(bus_wdata[A_W-1:0]))); // R2
  AST_DIR_B_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADR_B_DIR) |=> (pb_oe == $past(bus_wdata[B_W-1:0]))); // R2
  AST_DATA_A_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADR_A_DATA) |=> (pa_out == $past(bus_wdata[A_W-1:0]))); // R3
  AST_DATA_B_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADR_B_DATA) |=> (pb_out == $past(bus_wdata[B_W-1:0]))); // R3
  AST_OUT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADR_A_DATA)
      |-> ((bus_rdata[A_W-1:0] & pa_oe) == (pa_out & pa_oe))); // R4
  AST_PULL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == ADR_A_PULL || bus_addr == ADR_B_PULL))
      |-> (bus_rdata == 8'h00)); // R7
  AST_NO_PD_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pa_oe & pa_pd_en) == '0) && ((pb_oe & pb_pd_en) == '0)); // R9
  AST_PB_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == ADR_B_DATA || bus_addr == ADR_B_DIR))
      |-> ((bus_rdata >> B_W) == 8'h00)); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel || bus_wr) |-> (bus_rdata == 8'h00)); // R11
endmodule

bind gpio_pair_ctrl gpio_pair_ctrl_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pa_out   (pa_out),
  .pa_oe    (pa_oe),
  .pa_pd_en (pa_pd_en),
  .pb_out   (pb_out),
  .pb_oe    (pb_oe),
  .pb_pd_en (pb_pd_en)
);

// File: tb/gpio_pair_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_pair_ctrl_tb;
  localparam logic [7:0] AMASK = 8'h0F;
  localparam logic [5:0] BMASK = 6'b101010;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, wr;
  logic [7:0] addr, wdata, rdata;
  logic [7:0] pa_in, pa_out, pa_oe, pa_pu, pa_pd;
  logic [5:0] pb_in, pb_out, pb_oe, pb_pu, pb_pd;

  always #2 clk = ~clk;

  gpio_pair_ctrl #(.A_W(8), .B_W(6), .A_PU_MASK(AMASK), .B_PU_MASK(BMASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_pu_en(pa_pu), .pa_pd_en(pa_pd),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_pu_en(pb_pu), .pb_pd_en(pb_pd)
  );

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0, finished = 0;

  task automatic chk(input string tag, input string what, input logic [7:0] got,
                     input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %02h exp %02h", tag, what, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_alat, m_adir, m_apull;
  logic [5:0] m_blat, m_bdir, m_bpull;
  logic [7:0] a_hist[$];
  logic [5:0] b_hist[$];
  int         rel_cnt;

  initial begin
    a_hist = '{8'h00, 8'h00};
    b_hist = '{6'h00, 6'h00};
    rel_cnt = 0;
  end

  always @(posedge clk) begin
    if (!rst_n || rel_cnt < 2) begin
      if (!rst_n) rel_cnt = 0; else rel_cnt = rel_cnt + 1;
      m_alat = '0; m_adir = '0; m_apull = '0;
      m_blat = '0; m_bdir = '0; m_bpull = '0;
      a_hist = '{8'h00, 8'h00};
      b_hist = '{6'h00, 6'h00};
    end else begin
      if (sel && wr) begin
        if (addr == 8'h00) m_alat  = wdata;
        if (addr == 8'h04) m_adir  = wdata;
        if (addr == 8'h10) m_apull = wdata;
        if (addr == 8'h01) m_blat  = wdata[5:0];
        if (addr == 8'h05) m_bdir  = wdata[5:0];
        if (addr == 8'h11) m_bpull = wdata[5:0];
      end
      a_hist.push_front(pa_in); void'(a_hist.pop_back());
      b_hist.push_front(pb_in); void'(b_hist.pop_back());
    end
  end

  function automatic logic [7:0] exp_rdata();
    if (!sel || wr) return 8'h00;
    case (addr)
      8'h00: return (m_adir & m_alat) | (~m_adir & a_hist[1]);
      8'h01: return {2'b00, (m_bdir & m_blat) | (~m_bdir & b_hist[1])};
      8'h04: return m_adir;
      8'h05: return {2'b00, m_bdir};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag();
    if (!sel || wr) return "R11";
    case (addr)
      8'h00, 8'h01: return "R4 R5";
      8'h04, 8'h05: return "R2";
      8'h10, 8'h11: return "R7";
      default: return "R11";
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always begin
    @(negedge clk); #1;
    if (cmp_on && !finished) begin
      chk("R2", "pa_oe", pa_oe, m_adir);
      chk("R2", "pb_oe", {2'b0, pb_oe}, {2'b0, m_bdir});
      chk("R3", "pa_out", pa_out, m_alat);
      chk("R3", "pb_out", {2'b0, pb_out}, {2'b0, m_blat});
      chk("R8", "pa_pu", pa_pu, AMASK & ~m_apull);
      chk("R9", "pa_pd", pa_pd, ~AMASK & ~m_apull & ~m_adir);
      chk("R8", "pb_pu", {2'b0, pb_pu}, {2'b0, BMASK & ~m_bpull});
      chk("R9", "pb_pd", {2'b0, pb_pd}, {2'b0, ~BMASK & ~m_bpull & ~m_bdir});
      chk(rd_tag(), "rdata", rdata, exp_rdata());
    end
  end

  task automatic step(input logic s, input logic w, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] addrs[7];
    addrs = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h10, 8'h11, 8'h33};
    rst_n = 0; sel = 0; wr = 0; addr = 0; wdata = 0; pa_in = 8'h0C; pb_in = 6'h15;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cmp_on = 1;

    // R1 reset state
    step(1, 0, 8'h04, 0);
    chk("R1", "A dir read", rdata, 8'h00);
    chk("R1", "pa_oe", pa_oe, 8'h00);
    chk("R1", "pa_pu", pa_pu, AMASK);
    chk("R1", "pa_pd", pa_pd, ~AMASK);
    chk("R1", "pb_pu", {2'b0, pb_pu}, {2'b0, BMASK});
    chk("R1", "pb_pd", {2'b0, pb_pd}, {2'b0, ~BMASK});
    chk("R1", "pa_out", pa_out, 8'h00);

    // R2 direction write and readback
    step(1, 1, 8'h04, 8'hF0);
    step(1, 0, 8'h04, 0);
    chk("R2", "A dir read", rdata, 8'hF0);
    chk("R2", "pa_oe", pa_oe, 8'hF0);

    // R3/R4/R5 mixed data read
    step(1, 1, 8'h00, 8'h5A);
    step(0, 0, 0, 0);
    chk("R3", "pa_out", pa_out, 8'h5A);
    step(1, 0, 8'h00, 0);
    chk("R4", "output bits", rdata & 8'hF0, 8'h50);
    chk("R5", "input bits", rdata & 8'h0F, 8'h0C);

    // R6 write while input, then flip to output
    step(1, 1, 8'h05, 8'h00);
    step(1, 1, 8'h01, 8'h2D);
    step(0, 0, 0, 0);
    chk("R6", "pb_oe stays off", {2'b0, pb_oe}, 8'h00);
    step(1, 1, 8'h05, 8'h3F);
    step(1, 0, 8'h01, 0);
    chk("R6", "pb_out", {2'b0, pb_out}, 8'h2D);
    chk("R6", "pb_oe", {2'b0, pb_oe}, 8'h3F);
    chk("R6", "B data read", rdata, 8'h2D);

    // R9 pulls on driven port B
    chk("R9", "pb_pd off on outputs", {2'b0, pb_pd}, 8'h00);
    chk("R9", "pb_pu kept on outputs", {2'b0, pb_pu}, {2'b0, BMASK});

    // R8 active-low pull control, R7 write-only
    step(1, 1, 8'h10, 8'hFF);
    step(1, 0, 8'h10, 0);
    chk("R8", "pa_pu all off", pa_pu, 8'h00);
    chk("R8", "pa_pd all off", pa_pd, 8'h00);
    chk("R7", "A pull read", rdata, 8'h00);
    step(1, 1, 8'h04, 8'h00);
    step(1, 1, 8'h10, 8'h0A);
    step(0, 0, 0, 0);
    chk("R8", "pa_pu partial", pa_pu, 8'h05);
    chk("R9", "pa_pd inputs", pa_pd, 8'hF0);
    step(1, 1, 8'h11, 8'h3F);
    step(1, 0, 8'h11, 0);
    chk("R7", "B pull read", rdata, 8'h00);

    // R10 port B upper bits
    step(1, 1, 8'h01, 8'hFF);
    step(1, 0, 8'h01, 0);
    chk("R10", "B data read", rdata, 8'h3F);
    step(1, 1, 8'h05, 8'hC0);
    step(1, 0, 8'h05, 0);
    chk("R10", "B dir read", rdata, 8'h00);

    // R5 synchronizer latency, port A all inputs
    step(1, 0, 8'h00, 0);
    pa_in = 8'hA3;
    chk("R5", "before edges", rdata, 8'h0C);
    step(1, 0, 8'h00, 0);
    chk("R5", "after one edge", rdata, 8'h0C);
    step(1, 0, 8'h00, 0);
    chk("R5", "after two edges", rdata, 8'hA3);

    // R11 unmapped and idle
    step(1, 0, 8'h33, 0);
    chk("R11", "unmapped read", rdata, 8'h00);
    step(0, 0, 8'h00, 0);
    chk("R11", "idle", rdata, 8'h00);

    // mixed traffic, compared every cycle by the model
    for (int k = 0; k < 800; k++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           addrs[$urandom_range(0, 6)], 8'($urandom));
      if (k % 5 == 0) begin
        pa_in = 8'($urandom);
        pb_in = 6'($urandom);
      end
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    finish_run();
  end
endmodule